// File: doc/BRIEF.md
# Timer Input Capture Channel

This block records the value of an external free-running counter at the moment a chosen edge arrives on a capture pin. The recorded value first goes into a shadow register. It is then moved into a preload register, which is the only copy software can see. Software reads and writes the block over an 8-bit register bus. The 16-bit result is therefore read as a high byte followed by a low byte.

Between the high-byte read and the low-byte read, a read-in-progress latch holds back any new capture. This keeps the two bytes from ever coming from different captures. A capture that arrives during that window waits in the shadow register. It moves into the preload register one cycle after the low byte has been read.

Each capture sets a capture flag. A capture that lands while the flag is still set also sets an over-capture flag. The capture flag drives an interrupt line and a DMA request line, and each line has its own enable. Capture can be armed or disarmed. The active edge is selectable, and the trigger can be divided down so that only every 1st, 2nd, 4th or 8th qualifying edge causes a capture. A software write can also force a capture.

Top module: `cap_channel`

## Requirements
- R1: A capture happens only while CFG (address 0) has its mode field in bits [1:0] equal to 2'b01 and its arm bit [5] set. In every other setting, pin edges and software trigger writes change neither the status nor the captured value.
- R2: CFG bit [2] selects the active edge: 0 for rising and 1 for falling. The captured value is the counter input sampled on the clock edge where the pin first shows its new level. VHI (address 3) returns bits [15:8] of the captured value and VLO (address 4) returns bits [7:0].
- R3: The prescale field in CFG bits [4:3], value p, makes only every (1<<p)-th qualifying edge cause a capture. The edge count restarts from zero whenever the channel is disarmed.
- R4: STAT (address 1) bit 0 is the capture flag. Every capture sets it. It is cleared by writing STAT with bit 0 equal to 0, or by reading VLO. If a capture and a clear fall in the same cycle, the capture wins.
- R5: STAT bit 1 is the over-capture flag. It is set when a capture occurs while the capture flag is set, and only a STAT write with bit 1 equal to 0 clears it. Writing 1 to either STAT bit has no effect.
- R6: irq_o is high exactly while the capture flag and CFG bit [6] are both set. dma_req_o is high exactly while the capture flag and CFG bit [7] are both set.
- R7: Writing SWEV (address 2) with bit 0 equal to 1 forces a capture of the counter value in that cycle, with no prescaling. This is still subject to R1.
- R8: Reading VHI sets a read-in-progress latch and reading VLO clears it. While the latch is set, and also in the cycle of the VHI read itself, captures do not reach the preload register. A capture held back this way becomes visible one cycle after the VLO read.
- R9: Writes to VHI or VLO load that byte of the preload register, and reads return it. If a capture transfer falls in the same cycle, the transfer wins.
- R10: After reset, CFG, STAT and the preload register all read 0, and irq_o and dma_req_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Free-running counter value to capture |
| cap_in_i | input | 1 | Capture pin, already synchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; reads of VHI/VLO have side effects |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
A capture, its flags and the new preload value all appear registered after the clock edge that sees the qualifying pin level or the software trigger write. The bench therefore drives inputs on the falling clock edge and reads rdata_o shortly after the next falling edge, at least one full rising edge later. A capture held back by the read latch appears one rising edge after the VLO read. Because every bus access begins by waiting for a fresh falling edge, the very next read already falls after that edge. The interrupt and DMA lines follow the flag combinationally, so they are sampled in the same half cycle as the status read.

// File: rtl/cap_pkg.sv
package cap_pkg;
   typedef enum logic [2:0] {
      REG_CFG  = 3'd0,
      REG_STAT = 3'd1,
      REG_SWEV = 3'd2,
      REG_VHI  = 3'd3,
      REG_VLO  = 3'd4
   } cap_reg_e;

   localparam logic [1:0] MODE_CAPTURE = 2'b01;
endpackage

// File: rtl/cap_trigger.sv
module cap_trigger #(
   parameter int PSC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             armed_i,
   input  logic             pol_i,
   input  logic [PSC_W-1:0] psc_i,
   input  logic             pin_i,
   input  logic             sw_evt_i,
   output logic             cap_evt_o
);
   localparam int PCW = (1 << PSC_W) - 1;

   logic           prev_q;
   logic           edge_seen;
   logic           qualified;
   logic [PCW-1:0] pcnt_q;
   logic [PCW-1:0] term;
   logic           pres_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin_i;
   end

   assign edge_seen = pol_i ? (prev_q & ~pin_i) : (pin_i & ~prev_q);
   assign qualified = armed_i & edge_seen;
   assign term      = PCW'((32'd1 << psc_i) - 32'd1);
   assign pres_hit  = qualified && (pcnt_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pcnt_q <= '0;
      else if (!armed_i)  pcnt_q <= '0;
      else if (pres_hit)  pcnt_q <= '0;
      else if (qualified) pcnt_q <= pcnt_q + 1'b1;
   end

   assign cap_evt_o = armed_i & (pres_hit | sw_evt_i);
endmodule

// File: rtl/cap_hold.sv
module cap_hold #(
   parameter int CNT_W = 16,
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_evt_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             rd_hi_i,
   input  logic             rd_lo_i,
   input  logic             wr_hi_i,
   input  logic             wr_lo_i,
   input  logic [BUS_W-1:0] wdata_i,
   output logic [CNT_W-1:0] preload_o,
   output logic             rip_o
);
   logic [CNT_W-1:0] shadow_q;
   logic [CNT_W-1:0] preload_q;
   logic             pend_q;
   logic             rip_q;
   logic             blocked;
   logic             xfer_now;
   logic             xfer_pend;

   assign blocked   = rip_q | rd_hi_i;
   assign xfer_now  = cap_evt_i & ~blocked;
   assign xfer_pend = ~cap_evt_i & pend_q & ~blocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         pend_q   <= 1'b0;
      end else if (cap_evt_i) begin
         shadow_q <= cnt_i;
         pend_q   <= blocked;
      end else if (xfer_pend) begin
         pend_q   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         preload_q <= '0;
      end else if (xfer_now) begin
         preload_q <= cnt_i;
      end else if (xfer_pend) begin
         preload_q <= shadow_q;
      end else begin
         if (wr_lo_i) preload_q[BUS_W-1:0]       <= wdata_i;
         if (wr_hi_i) preload_q[CNT_W-1 -: BUS_W] <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rip_q <= 1'b0;
      else if (rd_hi_i) rip_q <= 1'b1;
      else if (rd_lo_i) rip_q <= 1'b0;
   end

   assign preload_o = preload_q;
   assign rip_o     = rip_q;
endmodule

// File: rtl/cap_channel.sv
module cap_channel
   import cap_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 3,
   parameter int PSC_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              cap_in_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BUS_W-1:0]  wdata_i,
   output logic [BUS_W-1:0]  rdata_o,
   output logic              irq_o,
   output logic              dma_req_o
);
   localparam int POL_B  = 2;
   localparam int PSC_LO = 3;
   localparam int CEN_B  = PSC_LO + PSC_W;
   localparam int IE_B   = CEN_B + 1;
   localparam int DE_B   = CEN_B + 2;

   if (CNT_W != 2 * BUS_W) begin : g_bad_width
      $error("cap_channel: CNT_W must be twice BUS_W");
   end
   if (DE_B >= BUS_W) begin : g_bad_cfg
      $error("cap_channel: config fields do not fit in BUS_W");
   end
   if (ADDR_W < 3 || PSC_W < 1) begin : g_bad_addr
      $error("cap_channel: ADDR_W must be at least 3 and PSC_W at least 1");
   end

   logic [BUS_W-1:0] cfg_q;
   logic             flag_q;
   logic             ovf_q;
   logic             sel_cfg, sel_stat, sel_swev, sel_vhi, sel_vlo;
   logic             wr_cfg, wr_stat, sw_evt;
   logic             rd_hi, rd_lo, wr_hi, wr_lo;
   logic             armed;
   logic             cap_evt;
   logic [CNT_W-1:0] preload;
   logic             rip;

   assign sel_cfg  = (addr_i == ADDR_W'(REG_CFG));
   assign sel_stat = (addr_i == ADDR_W'(REG_STAT));
   assign sel_swev = (addr_i == ADDR_W'(REG_SWEV));
   assign sel_vhi  = (addr_i == ADDR_W'(REG_VHI));
   assign sel_vlo  = (addr_i == ADDR_W'(REG_VLO));

   assign wr_cfg  = wr_en_i & sel_cfg;
   assign wr_stat = wr_en_i & sel_stat;
   assign sw_evt  = wr_en_i & sel_swev & wdata_i[0];
   assign wr_hi   = wr_en_i & sel_vhi;
   assign wr_lo   = wr_en_i & sel_vlo;
   assign rd_hi   = rd_en_i & sel_vhi;
   assign rd_lo   = rd_en_i & sel_vlo;

   assign armed = (cfg_q[1:0] == MODE_CAPTURE) & cfg_q[CEN_B];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (wr_cfg) cfg_q <= wdata_i;
   end

   cap_trigger #(.PSC_W(PSC_W)) u_trigger (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed_i   (armed),
      .pol_i     (cfg_q[POL_B]),
      .psc_i     (cfg_q[PSC_LO +: PSC_W]),
      .pin_i     (cap_in_i),
      .sw_evt_i  (sw_evt),
      .cap_evt_o (cap_evt)
   );

   cap_hold #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_evt_i (cap_evt),
      .cnt_i     (cnt_i),
      .rd_hi_i   (rd_hi),
      .rd_lo_i   (rd_lo),
      .wr_hi_i   (wr_hi),
      .wr_lo_i   (wr_lo),
      .wdata_i   (wdata_i),
      .preload_o (preload),
      .rip_o     (rip)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               flag_q <= 1'b0;
      else if (cap_evt)                         flag_q <= 1'b1;
      else if ((wr_stat & ~wdata_i[0]) | rd_lo) flag_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ovf_q <= 1'b0;
      else if (cap_evt & flag_q)       ovf_q <= 1'b1;
      else if (wr_stat & ~wdata_i[1])  ovf_q <= 1'b0;
   end

   always_comb begin
      rdata_o = '0;
      if (sel_cfg)  rdata_o = cfg_q;
      if (sel_stat) rdata_o = {{(BUS_W-2){1'b0}}, ovf_q, flag_q};
      if (sel_vhi)  rdata_o = preload[CNT_W-1 -: BUS_W];
      if (sel_vlo)  rdata_o = preload[BUS_W-1:0];
   end

   assign irq_o     = flag_q & cfg_q[IE_B];
   assign dma_req_o = flag_q & cfg_q[DE_B];
endmodule

// File: rtl/cap_channel_chk.sv
module cap_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cap_evt,
   input logic             armed,
   input logic             flag,
   input logic             ovf,
   input logic             rd_hi,
   input logic             wr_hi,
   input logic             wr_lo,
   input logic             rip,
   input logic [CNT_W-1:0] preload
);
   assert_idle_when_disarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !cap_evt);

   assert_flag_on_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> flag);

   assert_ovf_on_recapture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt && flag) |=> ovf);

   assert_hi_read_latches_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi |=> rip);

   assert_hold_while_reading_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rip && !wr_hi && !wr_lo) |=> $stable(preload));
endmodule

bind cap_channel cap_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cap_evt (cap_evt),
   .armed   (armed),
   .flag    (flag_q),
   .ovf     (ovf_q),
   .rd_hi   (rd_hi),
   .wr_hi   (wr_hi),
   .wr_lo   (wr_lo),
   .rip     (rip),
   .preload (preload)
);

// File: tb/test_cap_channel.sv
module test_cap_channel;
   localparam int CLK_P = 10;
   localparam logic [2:0] A_CFG = 3'd0, A_STAT = 3'd1, A_SWEV = 3'd2, A_VHI = 3'd3, A_VLO = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt = 16'hA5F0;
   logic        cap_in = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        irq, dma;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [15:0] wr_cnt;

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cnt <= cnt + 16'h0103;

   cap_channel i_cap_channel (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cap_in_i(cap_in),
      .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .irq_o(irq), .dma_req_o(dma)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1; wr_cnt = cnt;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse(input bit pol, output logic [15:0] exp);
      @(negedge clk);
      cap_in = 1'b1;
      if (!pol) exp = cnt;
      @(negedge clk);
      cap_in = 1'b0;
      if (pol) exp = cnt;
      @(negedge clk);
   endtask

   task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
      logic [7:0] d;
      bus_rd(a, d);
      check(tag, {24'd0, d}, {24'd0, exp});
   endtask

   initial begin
      logic [15:0] e1, e2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state
      rd_chk("R10 cfg", A_CFG, 8'h00);
      rd_chk("R10 stat", A_STAT, 8'h00);
      rd_chk("R10 vhi", A_VHI, 8'h00);
      rd_chk("R10 vlo", A_VLO, 8'h00);
      check("R10 irq/dma", {30'd0, irq, dma}, 32'd0);

      // R1: wrong mode, armed; then right mode, not armed
      bus_wr(A_CFG, 8'h20);
      pulse(1'b0, e1);
      bus_wr(A_SWEV, 8'h01);
      rd_chk("R1 mode00 stat", A_STAT, 8'h00);
      rd_chk("R1 mode00 vhi", A_VHI, 8'h00);
      bus_wr(A_CFG, 8'h01);
      pulse(1'b0, e1);
      bus_wr(A_SWEV, 8'h01);
      rd_chk("R1 disarmed stat", A_STAT, 8'h00);
      rd_chk("R1 disarmed vlo", A_VLO, 8'h00);

      // R2/R3/R4: sweep polarity and prescale
      for (int pol = 0; pol < 2; pol++) begin
         for (int p = 0; p < 4; p++) begin
            bus_wr(A_CFG, 8'h00);
            bus_wr(A_CFG, 8'h21 | 8'(pol << 2) | 8'(p << 3));
            for (int k = 0; k < (1 << p) - 1; k++) pulse(pol[0], e1);
            rd_chk($sformatf("R3 pol%0d psc%0d early", pol, p), A_STAT, 8'h00);
            pulse(pol[0], e1);
            rd_chk($sformatf("R4 pol%0d psc%0d flag", pol, p), A_STAT, 8'h01);
            rd_chk($sformatf("R2 pol%0d psc%0d hi", pol, p), A_VHI, e1[15:8]);
            rd_chk($sformatf("R2 pol%0d psc%0d lo", pol, p), A_VLO, e1[7:0]);
            rd_chk($sformatf("R4 pol%0d psc%0d lo-read clear", pol, p), A_STAT, 8'h00);
         end
      end

      // R5: over-capture
      bus_wr(A_CFG, 8'h21);
      pulse(1'b0, e1);
      pulse(1'b0, e2);
      rd_chk("R5 ovf set", A_STAT, 8'h03);
      bus_wr(A_STAT, 8'h03);
      rd_chk("R5 write ones no effect", A_STAT, 8'h03);
      bus_wr(A_STAT, 8'h01);
      rd_chk("R5 ovf cleared only", A_STAT, 8'h01);
      bus_wr(A_STAT, 8'h00);
      rd_chk("R4 write-zero clear", A_STAT, 8'h00);
      rd_chk("R2 latest hi", A_VHI, e2[15:8]);
      rd_chk("R2 latest lo", A_VLO, e2[7:0]);

      // R6: interrupt and DMA requests
      bus_wr(A_CFG, 8'h61);
      pulse(1'b0, e1);
      check("R6 irq", {30'd0, irq, dma}, 32'd2);
      bus_wr(A_CFG, 8'hA1);
      check("R6 dma", {30'd0, irq, dma}, 32'd1);
      bus_wr(A_STAT, 8'h00);
      check("R6 cleared", {30'd0, irq, dma}, 32'd0);

      // R7: software trigger bypasses prescale of 8
      bus_wr(A_CFG, 8'h00);
      bus_wr(A_CFG, 8'h39);
      bus_wr(A_SWEV, 8'h01);
      e1 = wr_cnt;
      rd_chk("R7 flag", A_STAT, 8'h01);
      rd_chk("R7 hi", A_VHI, e1[15:8]);
      rd_chk("R7 lo", A_VLO, e1[7:0]);

      // R8: read-in-progress holds a new capture back
      bus_wr(A_CFG, 8'h21);
      pulse(1'b0, e1);
      rd_chk("R8 old hi", A_VHI, e1[15:8]);
      pulse(1'b0, e2);
      rd_chk("R8 lo not torn", A_VLO, e1[7:0]);
      rd_chk("R8 held hi", A_VHI, e2[15:8]);
      rd_chk("R8 held lo", A_VLO, e2[7:0]);

      // R9: preload byte writes
      bus_wr(A_CFG, 8'h00);
      bus_wr(A_VHI, 8'h3C);
      bus_wr(A_VLO, 8'hC3);
      rd_chk("R9 hi", A_VHI, 8'h3C);
      rd_chk("R9 lo", A_VLO, 8'hC3);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule